// File: doc/BRIEF.md
# Parallel printer port controller

This block sits on a simple host register bus and drives an 8-bit parallel printer interface. Software sees a byte-wide output latch for the printer data lines, a read-only view of the five printer status lines, and a control byte that drives four output control lines and holds an interrupt enable. Each status line passes through a two-stage synchroniser before the host or the interrupt logic sees it.

A fourth address hosts a hardware send engine. Writing a byte there starts a sequence that needs no software timing. The engine waits for the printer's ready line and then loads the byte onto the data lines. It holds the data for a setup interval, raises the strobe for a pulse interval, and keeps the data steady for a hold interval before it returns to idle. While the engine runs, its busy flag reads as 1, and the host cannot disturb the data latch or the strobe bit.

An interrupt request rises on each acknowledge edge from the printer while interrupts are enabled. A read of the status register clears it.

Top module: `prn_port`

## Requirements
- R1: Address 0 is the data latch. A write stores the bus byte, which appears on `pr_data` after the write edge. A read returns the stored byte.
- R2: A read of address 1 returns the synchronised status lines as bit 7 = ready, bit 6 = acknowledge, bit 5 = paper-out, bit 4 = online, bit 3 = fault, with bits 2..0 read as 0. A change on an input shows in a read after two rising clock edges and not after one.
- R3: Address 2 is the control byte. Bit 0 drives the strobe line, bit 1 auto-feed, bit 2 init and bit 3 select. Bit 4 is the interrupt enable and drives no line. Bits 7..5 read as 0.
- R4: A read of address 3 returns the engine busy flag in bit 0 and 0 in bits 7..1. A write to address 3 while idle starts the engine with the written byte. A write to address 3 while busy is ignored.
- R5: While the synchronised ready line (status bit 7) is 0, the engine waits. It does not load the data latch and does not strobe.
- R6: Once ready, the engine loads its byte onto `pr_data`. It then holds the data for SETUP_CYC cycles with strobe low, drives `pr_strobe` high for exactly STROBE_CYC cycles, and keeps the data for HOLD_CYC further cycles. After that, busy clears and the strobe line returns to control bit 0. The data is stable through all three phases.
- R7: While the engine is busy, writes to the data latch are ignored and control bit 0 keeps its value. Control bits 4..1 still update.
- R8: With control bit 4 set, a rising edge of the synchronised acknowledge line sets `irq` three rising clock edges after the input rises. With bit 4 clear, an acknowledge edge leaves `irq` low.
- R9: A read of address 1 clears `irq`.
- R10: After reset, the data latch, the control byte, `irq` and the busy flag are all 0, and every output line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pr_data | output | 8 | Printer data lines |
| pr_strobe | output | 1 | Strobe line |
| pr_autofeed | output | 1 | Auto-feed line |
| pr_init | output | 1 | Init line |
| pr_select | output | 1 | Select line |
| pr_ready | input | 1 | Printer ready (1 = can accept a byte) |
| pr_ack | input | 1 | Acknowledge line |
| pr_paper | input | 1 | Paper-out line |
| pr_online | input | 1 | Online line |
| pr_fault | input | 1 | Fault line |
| irq | output | 1 | Interrupt request |

## Verification
Register writes are due on the pins one edge after the write edge. Status changes are due in a read two edges after the input changes. An acknowledge edge sets `irq` on the third edge. The bench drives its stimulus and samples results at falling edges. It checks the status and interrupt results one cycle before and again at their due cycle, so an extra or missing flop is reported. For the send engine, the bench keeps address 3 selected for reading and counts, falling edge by falling edge, the cycles spent in setup, strobe and hold. It compares each count against the configured length.

// File: rtl/prn_pkg.sv
package prn_pkg;
  typedef enum logic [2:0] {
    ENG_IDLE, ENG_WAIT, ENG_SETUP, ENG_STROBE, ENG_HOLD
  } eng_state_t;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_SEND = 2'd3;

  // lines = {ready, ack, paper, online, fault}
  function automatic logic [7:0] status_word(logic [4:0] lines);
    return {lines, 3'b000};
  endfunction

  // Control update: strobe bit frozen while the engine owns the line
  function automatic logic [4:0] ctrl_next(logic [4:0] cur, logic [7:0] wd, logic eng_busy);
    return eng_busy ? {wd[4:1], cur[0]} : wd[4:0];
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/prn_sync.sv
module prn_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/prn_irq.sv
module prn_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_s,
  input  logic en,
  input  logic clr,
  output logic irq,
  output logic ack_rise
);
  logic ack_d;

  assign ack_rise = ack_s & ~ack_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_d <= 1'b0;
      irq   <= 1'b0;
    end else begin
      ack_d <= ack_s;
      if (en && ack_rise) irq <= 1'b1;
      else if (clr)       irq <= 1'b0;
    end
  end

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en)); // R8
  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ack_rise) |=> !irq); // R9
endmodule

// File: rtl/prn_send_fsm.sv
module prn_send_fsm
  import prn_pkg::*;
#(
  parameter int SETUP_CYC  = 4,
  parameter int STROBE_CYC = 4,
  parameter int HOLD_CYC   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] start_byte,
  input  logic       ready,
  output logic       busy,
  output logic       strobe,
  output logic       load,
  output logic [7:0] out_byte
);
  localparam int MAXC  = max3(SETUP_CYC, STROBE_CYC, HOLD_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  eng_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       byte_q;

  assign busy     = (state != ENG_IDLE);
  assign strobe   = (state == ENG_STROBE);
  assign load     = (state == ENG_WAIT) && ready;
  assign out_byte = byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ENG_IDLE;
      cnt    <= '0;
      byte_q <= '0;
    end else begin
      case (state)
        ENG_IDLE: if (start) begin
          byte_q <= start_byte;
          state  <= ENG_WAIT;
        end
        ENG_WAIT: if (ready) begin
          state <= ENG_SETUP;
          cnt   <= CNT_W'(SETUP_CYC - 1);
        end
        ENG_SETUP: if (cnt == '0) begin
          state <= ENG_STROBE;
          cnt   <= CNT_W'(STROBE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ENG_STROBE: if (cnt == '0) begin
          state <= ENG_HOLD;
          cnt   <= CNT_W'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ENG_HOLD: if (cnt == '0) state <= ENG_IDLE;
                  else cnt <= cnt - 1'b1;
        default: state <= ENG_IDLE;
      endcase
    end
  end

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENG_WAIT && !ready) |=> (state == ENG_WAIT)); // R5
  AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> ($past(state) == ENG_SETUP)); // R6
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(byte_q)); // R4
endmodule

// File: rtl/prn_port.sv
module prn_port
  import prn_pkg::*;
#(
  parameter int SETUP_CYC  = 4,
  parameter int STROBE_CYC = 4,
  parameter int HOLD_CYC   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [7:0] pr_data,
  output logic       pr_strobe,
  output logic       pr_autofeed,
  output logic       pr_init,
  output logic       pr_select,
  input  logic       pr_ready,
  input  logic       pr_ack,
  input  logic       pr_paper,
  input  logic       pr_online,
  input  logic       pr_fault,
  output logic       irq
);
  localparam int NLINES = 5;

  logic [NLINES-1:0] lines_s;
  logic [7:0]        data_q;
  logic [4:0]        ctrl_q;
  logic              eng_busy, eng_strobe, eng_load, ack_rise;
  logic [7:0]        eng_byte;

  // Named bus events
  logic wr_data, wr_ctrl, wr_send, status_rd;
  assign wr_data   = bus_sel &  bus_wr & (bus_addr == A_DATA);
  assign wr_ctrl   = bus_sel &  bus_wr & (bus_addr == A_CTRL);
  assign wr_send   = bus_sel &  bus_wr & (bus_addr == A_SEND);
  assign status_rd = bus_sel & ~bus_wr & (bus_addr == A_STAT);

  prn_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n,
    .din  ({pr_ready, pr_ack, pr_paper, pr_online, pr_fault}),
    .dout (lines_s)
  );

  prn_send_fsm #(.SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)) u_eng (
    .clk, .rst_n,
    .start      (wr_send),
    .start_byte (bus_wdata),
    .ready      (lines_s[4]),
    .busy       (eng_busy),
    .strobe     (eng_strobe),
    .load       (eng_load),
    .out_byte   (eng_byte)
  );

  prn_irq u_irq (
    .clk, .rst_n,
    .ack_s    (lines_s[3]),
    .en       (ctrl_q[4]),
    .clr      (status_rd),
    .irq      (irq),
    .ack_rise (ack_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (eng_load)                 data_q <= eng_byte;
      else if (wr_data && !eng_busy) data_q <= bus_wdata;
      if (wr_ctrl) ctrl_q <= ctrl_next(ctrl_q, bus_wdata, eng_busy);
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = data_q;
      A_STAT:  bus_rdata = status_word(lines_s);
      A_CTRL:  bus_rdata = {3'b000, ctrl_q};
      default: bus_rdata = {7'b0, eng_busy};
    endcase
  end

  assign pr_data     = data_q;
  assign pr_strobe   = ctrl_q[0] | eng_strobe;
  assign pr_autofeed = ctrl_q[1];
  assign pr_init     = ctrl_q[2];
  assign pr_select   = ctrl_q[3];

  AST_STATUS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |-> (bus_rdata[2:0] == 3'b000)); // R2
  AST_DATA_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && wr_data && !eng_load) |=> $stable(data_q)); // R7
  AST_STR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && wr_ctrl) |=> $stable(ctrl_q[0])); // R7
  AST_DATA_STABLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_strobe |-> $stable(data_q)); // R6
endmodule

// File: tb/prn_port_test.sv
`timescale 1ns/1ps
module prn_port_test;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata, pr_data;
  logic       pr_strobe, pr_autofeed, pr_init, pr_select, irq;
  logic       pr_ready = 1'b0, pr_ack = 1'b0, pr_paper = 1'b0, pr_online = 1'b0, pr_fault = 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  prn_port #(.SETUP_CYC(N), .STROBE_CYC(N), .HOLD_CYC(N)) uut (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .pr_data, .pr_strobe, .pr_autofeed, .pr_init, .pr_select,
    .pr_ready, .pr_ack, .pr_paper, .pr_online, .pr_fault, .irq
  );

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d exp<=150000", cyc);
      summary();
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  // Count engine phases with address 3 held selected for reading
  task automatic measure(logic [7:0] b);
    int ns = 0, nst = 0, nh = 0;
    bit stable_ok = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd3;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (bus_rdata[0] == 1'b0) break;
      if (pr_strobe) begin
        nst++;
        if (pr_data != b) stable_ok = 1'b0;
      end else if (pr_data == b) begin
        if (nst == 0) ns++; else nh++;
      end else if (nst > 0) stable_ok = 1'b0;
    end
    bus_sel = 1'b0;
    chk(ns == N,  "R6 setup cycles", ns, N);
    chk(nst == N, "R6 strobe cycles", nst, N);
    chk(nh == N,  "R6 hold cycles", nh, N);
    chk(stable_ok, "R6 data stable", pr_data, b);
    chk(pr_strobe == 1'b0, "R6 strobe back to ctrl bit0", pr_strobe, 0);
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    @(negedge clk);
    chk(pr_data == 8'h00, "R10 data", pr_data, 0);
    chk({pr_strobe, pr_autofeed, pr_init, pr_select, irq} == 5'b0, "R10 lines",
        {pr_strobe, pr_autofeed, pr_init, pr_select, irq}, 0);
    bus_read(2'd2, rd); chk(rd == 8'h00, "R10 ctrl", rd, 0);
    bus_read(2'd3, rd); chk(rd == 8'h00, "R10/R4 busy idle", rd, 0);

    // R1 data latch sweep
    for (int v = 0; v < 256; v++) begin
      bus_write(2'd0, 8'(v));
      @(negedge clk);
      chk(pr_data == 8'(v), "R1 pr_data", pr_data, v);
      bus_read(2'd0, rd);
      chk(rd == 8'(v), "R1 readback", rd, v);
    end

    // R3 control sweep
    for (int v = 0; v < 256; v++) begin
      bus_write(2'd2, 8'(v));
      @(negedge clk);
      chk({pr_select, pr_init, pr_autofeed, pr_strobe} == 4'(v % 16), "R3 lines",
          {pr_select, pr_init, pr_autofeed, pr_strobe}, v % 16);
      bus_read(2'd2, rd);
      chk(rd == 8'(v % 32), "R3 readback", rd, v % 32);
    end
    bus_write(2'd2, 8'h00);

    // R2 status sweep
    for (int v = 0; v < 32; v++) begin
      @(negedge clk);
      {pr_ready, pr_ack, pr_paper, pr_online, pr_fault} = 5'(v);
      @(posedge clk); @(posedge clk);
      bus_read(2'd1, rd);
      chk(rd == 8'(v * 8), "R2 status", rd, v * 8);
    end
    // R2 synchroniser latency: not visible after one edge
    @(negedge clk);
    {pr_ready, pr_ack, pr_paper, pr_online, pr_fault} = 5'b00000;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    pr_paper = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd1;
    #1 chk(bus_rdata == 8'h00, "R2 one edge", bus_rdata, 0);
    @(negedge clk);
    chk(bus_rdata == 8'h20, "R2 two edges", bus_rdata, 8'h20);
    bus_sel = 1'b0;
    pr_paper = 1'b0;

    // R8/R9 interrupt
    bus_write(2'd2, 8'h10);
    @(negedge clk) pr_ack = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) chk(irq == 1'b0, "R8 irq after two edges", irq, 0);
    @(negedge clk) chk(irq == 1'b1, "R8 irq after three edges", irq, 1);
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R9 irq held", irq, 1);
    bus_read(2'd1, rd);
    @(negedge clk) chk(irq == 1'b0, "R9 cleared by status read", irq, 0);
    bus_write(2'd2, 8'h00);
    @(negedge clk) pr_ack = 1'b0;
    repeat (4) @(negedge clk);
    pr_ack = 1'b1;
    repeat (6) @(negedge clk);
    chk(irq == 1'b0, "R8 disabled no irq", irq, 0);
    pr_ack = 1'b0;

    // R5/R7/R4 engine blocked by not-ready
    bus_write(2'd0, 8'h5A);
    pr_ready = 1'b0;
    repeat (3) @(negedge clk);
    bus_write(2'd3, 8'hA5);
    repeat (8) @(negedge clk);
    chk(pr_data == 8'h5A, "R5 no load while not ready", pr_data, 8'h5A);
    chk(pr_strobe == 1'b0, "R5 no strobe while not ready", pr_strobe, 0);
    bus_read(2'd3, rd); chk(rd == 8'h01, "R4 busy flag", rd, 1);
    bus_write(2'd0, 8'h11);
    @(negedge clk) chk(pr_data == 8'h5A, "R7 data write ignored", pr_data, 8'h5A);
    bus_write(2'd2, 8'h0F);
    @(negedge clk);
    chk({pr_select, pr_init, pr_autofeed, pr_strobe} == 4'b1110, "R7 ctrl lines while busy",
        {pr_select, pr_init, pr_autofeed, pr_strobe}, 4'b1110);
    bus_read(2'd2, rd); chk(rd == 8'h0E, "R7 str bit kept", rd, 8'h0E);
    bus_write(2'd3, 8'h22);
    bus_write(2'd2, 8'h00);
    @(negedge clk) pr_ready = 1'b1;
    measure(8'hA5);
    chk(pr_data == 8'hA5, "R4 second trigger ignored", pr_data, 8'hA5);

    // R6 second send with ready already high
    bus_write(2'd3, 8'h3C);
    measure(8'h3C);
    bus_read(2'd3, rd); chk(rd == 8'h00, "R4 busy cleared", rd, 0);
    bus_write(2'd0, 8'h77);
    @(negedge clk) chk(pr_data == 8'h77, "R1 data write after engine", pr_data, 8'h77);

    summary();
  end
endmodule